// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the device side of a parallel NOR flash that is driven by the classic unlock-based write command protocol. Every bus write cycle (strobe, word address, data byte) is decoded against a small sequencer that tracks the unlock stage, the command waiting for its argument, whether the unlock-bypass shortcut is active, and whether an erase is still running. Program and erase operations are applied to an internal byte array. Programming can only clear bits. Erasing sets a whole sector, or the whole array, back to all ones.

A separate read path uses the mode output to choose what a read returns: array data, identification data, the query table or the status byte. That read path is outside this block. The array contents are visible on a combinational read port. Erase takes a configurable number of clock cycles. During that time the block is busy and does not act on any write. When the erase finishes, bit 7 of the status byte flips.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset the mode output is array read (code 0), busy and bypass are low, the status byte is 0x00 and every array byte reads 0xFF.
- R2: From read mode, a command is only reached after 0xAA is written at address UNLK0 and then 0x55 is written at address UNLK1. A wrong value or a wrong address at either step returns the block to read mode.
- R3: On the third cycle, 0x90 written at UNLK0 enters autoselect (mode code 1). When bypass is off, a command written at any other address returns the block to read mode.
- R4: The third cycle 0xA0 makes the next write a program cycle, and the mode during that wait is status (code 3). The program cycle stores old AND data at array index wr_addr[MEM_AW-1:0]. It sets the status byte to 0x7F when data bit 7 is 1 and to 0xFF otherwise. The block then returns to read mode.
- R5: Writing 0xF0 returns the block to read mode and clears bypass at any non-busy stage. The one exception is while a program cycle is awaited: there, 0xF0 is programmed as data.
- R6: 0x80, then 0xAA at UNLK0, then 0x55 at UNLK1, then 0x10 at UNLK0 sets every array byte to 0xFF and holds busy high for CHIP_CYC cycles. If 0x10 is written at any other address, the block returns to read mode.
- R7: The same setup ending with 0x30 at any address sets only the sector wr_addr[MEM_AW-1:SECT_AW] to 0xFF and holds busy high for SECT_CYC cycles.
- R8: While busy, every write is ignored, including 0xF0 and a write in the final busy cycle. At the end of the erase, status bit 7 inverts (the erase start clears the status byte to 0x00). The block then goes back to read mode, or to the command stage when bypass is set.
- R9: 0x20 on the third cycle sets bypass and keeps the block at the command stage. In bypass, commands need no unlock and may use any address, and each program cycle returns the block to the command stage. Writing 0x00 while in autoselect under bypass clears bypass.
- R10: 0x98 written at address QRY_ADDR, from read mode or from autoselect, enters query mode (code 2). Any write while in query mode returns the block to read mode.
- R11: Any third-cycle value other than 0x20, 0x80, 0x90 or 0xA0 returns the block to read mode, so a following write does not program the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 8 | Data or command byte of the write |
| rd_addr | input | MEM_AW | Array read index |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| mode_o | output | 2 | Read-path selector: 0 array, 1 autoselect, 2 query, 3 status |
| status_o | output | 8 | Status byte for the read path |
| busy_o | output | 1 | Erase in progress |
| bypass_o | output | 1 | Unlock bypass active |

## Verification
Erase completion and an incoming bus write can land in the same clock cycle. On that edge the sequencer leaves the busy state and would also be free to decode a write. The bench provokes this during a sector erase: it drives 0xAA at UNLK0 exactly in the last busy cycle. It then writes 0x55 at UNLK1 and 0x90 at UNLK0. If the colliding write had been accepted, autoselect would be reached. The bench expects array read mode, together with busy low and the inverted status bit.

// File: rtl/nfc_pkg.sv
// Shared types and command codes for the NOR flash command sequencer.
// Assumes byte-wide commands on the low data lane.
package nfc_pkg;

    typedef enum logic [2:0] {
        ST_READ,    // normal read, waiting for first unlock
        ST_UNL1,    // first unlock seen
        ST_CMD,     // command stage
        ST_ARG,     // command pending its argument cycle
        ST_EUNL1,   // erase setup: second first-unlock seen
        ST_ECMD,    // erase setup: waiting for erase code
        ST_BUSY,    // erase in progress
        ST_QUERY    // query table mode
    } seq_state_t;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_PROG,
        PD_ESET,
        PD_AUTO
    } pend_t;

    typedef enum logic [1:0] {
        MD_ARRAY   = 2'd0,
        MD_AUTOSEL = 2'd1,
        MD_QUERY   = 2'd2,
        MD_STATUS  = 2'd3
    } mode_t;

    localparam logic [7:0] CODE_KEY_A  = 8'hAA;
    localparam logic [7:0] CODE_KEY_B  = 8'h55;
    localparam logic [7:0] CODE_ESET   = 8'h80;
    localparam logic [7:0] CODE_AUTO   = 8'h90;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_BYP    = 8'h20;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_QRY    = 8'h98;
    localparam logic [7:0] CODE_ESCAPE = 8'hF0;
    localparam logic [7:0] CODE_BYPEND = 8'h00;

endpackage

// File: rtl/nfc_timer.sv
// Erase busy timer: a down-counter loaded with the chip or sector duration.
// Assumes start is pulsed only while idle; done is high in the last busy cycle.
module nfc_timer #(
    parameter int CHIP_CYC = 40,
    parameter int SECT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_chip,
    output logic done
);
    localparam int MAXC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign done = run_q && (cnt_q == '0);

    // Load on start, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= sel_chip ? CW'(CHIP_CYC - 1) : CW'(SECT_CYC - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6 R7
    stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == '0 && !start) |=> !run_q);
    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);
endmodule

// File: rtl/nfc_array.sv
// Byte storage: AND-only programming, sector erase and chip erase to 0xFF.
// Assumes at most one of prog/sector/chip is requested per cycle.
module nfc_array #(
    parameter int MEM_AW  = 8,
    parameter int SECT_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              sect_er,
    input  logic              chip_er,
    input  logic [MEM_AW-1:0] idx,
    input  logic [7:0]        wdata,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << MEM_AW;
    localparam int SW    = MEM_AW - SECT_AW;

    logic [7:0] mem [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cell
            localparam logic [MEM_AW-1:0] GI = MEM_AW'(g);
            // Each cell erases, clears bits on program, or holds.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= 8'hFF;
                else if (chip_er)
                    mem[g] <= 8'hFF;
                else if (sect_er && GI[MEM_AW-1:SECT_AW] == idx[MEM_AW-1:SECT_AW])
                    mem[g] <= 8'hFF;
                else if (prog_en && GI == idx)
                    mem[g] <= mem[g] & wdata;
            end
        end
    endgenerate

    assign rd_data = mem[rd_addr];

    // R4: a program may only clear bits of the addressed byte
    prog_and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !sect_er && !chip_er && rd_addr == idx)
        |=> ((rd_data & ~$past(rd_data)) == 8'h00) || (rd_addr != $past(rd_addr)));

    initial begin
        sw_chk: assert (SW >= 0);
    end
endmodule

// File: rtl/nfc_seq.sv
// Command sequencer: decodes write cycles into unlock steps, commands,
// program/erase requests, bypass, query and the status byte.
// Assumes one write per wr_en cycle; timer done arrives only while busy.
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int          AW       = 12,
    parameter logic [AW-1:0] UNLK0  = 12'h555,
    parameter logic [AW-1:0] UNLK1  = 12'h2AA,
    parameter logic [AW-1:0] QRY_ADDR = 12'h055
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          tmr_done,
    output logic          prog_en,
    output logic          sect_er,
    output logic          chip_er,
    output logic          tmr_start,
    output logic          tmr_chip,
    output logic [1:0]    mode,
    output logic [7:0]    status,
    output logic          busy,
    output logic          bypass
);
    seq_state_t st_q, st_n;
    pend_t      pd_q, pd_n;
    logic       byp_q, byp_n;
    logic [7:0] stat_q, stat_n;
    logic       to_read;

    logic at_u0, at_u1, is_qry, esc;
    assign at_u0  = (wr_addr == UNLK0);
    assign at_u1  = (wr_addr == UNLK1);
    assign is_qry = (wr_addr == QRY_ADDR) && (wr_data == CODE_QRY);
    assign esc    = (wr_data == CODE_ESCAPE) && !(st_q == ST_ARG && pd_q == PD_PROG);

    // Next-state decode of one write cycle or erase completion.
    always_comb begin
        st_n = st_q; pd_n = pd_q; byp_n = byp_q; stat_n = stat_q;
        prog_en = 1'b0; sect_er = 1'b0; chip_er = 1'b0;
        tmr_start = 1'b0; tmr_chip = 1'b0; to_read = 1'b0;
        if (st_q == ST_BUSY) begin
            if (tmr_done) begin
                stat_n = stat_q ^ 8'h80;
                st_n   = byp_q ? ST_CMD : ST_READ;
                pd_n   = PD_NONE;
            end
        end else if (wr_en) begin
            if (esc) begin
                to_read = 1'b1;
            end else begin
                case (st_q)
                    ST_READ: begin
                        if (is_qry)                               st_n = ST_QUERY;
                        else if (at_u0 && wr_data == CODE_KEY_A)  st_n = ST_UNL1;
                        else                                      to_read = 1'b1;
                    end
                    ST_UNL1: begin
                        if (at_u1 && wr_data == CODE_KEY_B) st_n = ST_CMD;
                        else                                to_read = 1'b1;
                    end
                    ST_CMD: begin
                        if (!byp_q && !at_u0) to_read = 1'b1;
                        else begin
                            case (wr_data)
                                CODE_BYP:  byp_n = 1'b1;
                                CODE_ESET: begin st_n = ST_ARG; pd_n = PD_ESET; end
                                CODE_AUTO: begin st_n = ST_ARG; pd_n = PD_AUTO; end
                                CODE_PROG: begin st_n = ST_ARG; pd_n = PD_PROG; end
                                default:   to_read = 1'b1;
                            endcase
                        end
                    end
                    ST_ARG: begin
                        case (pd_q)
                            PD_PROG: begin
                                prog_en = 1'b1;
                                stat_n  = {~wr_data[7], 7'h7F};
                                if (byp_q) begin st_n = ST_CMD; pd_n = PD_NONE; end
                                else to_read = 1'b1;
                            end
                            PD_ESET: begin
                                if (is_qry) begin st_n = ST_QUERY; pd_n = PD_NONE; end
                                else if (at_u0 && wr_data == CODE_KEY_A) st_n = ST_EUNL1;
                                else to_read = 1'b1;
                            end
                            PD_AUTO: begin
                                if (byp_q && wr_data == CODE_BYPEND) to_read = 1'b1;
                                else if (is_qry) begin st_n = ST_QUERY; pd_n = PD_NONE; end
                                else to_read = 1'b1;
                            end
                            default: to_read = 1'b1;
                        endcase
                    end
                    ST_EUNL1: begin
                        if (at_u1 && wr_data == CODE_KEY_B) st_n = ST_ECMD;
                        else                                to_read = 1'b1;
                    end
                    ST_ECMD: begin
                        if (wr_data == CODE_CHIP && at_u0) begin
                            chip_er = 1'b1; tmr_start = 1'b1; tmr_chip = 1'b1;
                            stat_n = 8'h00; st_n = ST_BUSY;
                        end else if (wr_data == CODE_SECT) begin
                            sect_er = 1'b1; tmr_start = 1'b1;
                            stat_n = 8'h00; st_n = ST_BUSY;
                        end else begin
                            to_read = 1'b1;
                        end
                    end
                    default: to_read = 1'b1;   // query or unexpected: leave
                endcase
            end
            if (to_read) begin
                st_n = ST_READ; pd_n = PD_NONE; byp_n = 1'b0;
            end
        end
    end

    // State, pending command, bypass flag and status byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_READ;
            pd_q   <= PD_NONE;
            byp_q  <= 1'b0;
            stat_q <= 8'h00;
        end else begin
            st_q   <= st_n;
            pd_q   <= pd_n;
            byp_q  <= byp_n;
            stat_q <= stat_n;
        end
    end

    // Mode presented to the read path.
    always_comb begin
        case (st_q)
            ST_ARG:   mode = (pd_q == PD_AUTO) ? MD_AUTOSEL :
                             (pd_q == PD_PROG) ? MD_STATUS : MD_ARRAY;
            ST_BUSY:  mode = MD_STATUS;
            ST_QUERY: mode = MD_QUERY;
            default:  mode = MD_ARRAY;
        endcase
    end

    assign status = stat_q;
    assign busy   = (st_q == ST_BUSY);
    assign bypass = byp_q;

    // R8: busy holds until the timer reports done, bypass untouched
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && !tmr_done) |=> (st_q == ST_BUSY) && $stable(byp_q));
    // R8: completion inverts status bit 7
    done_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BUSY && tmr_done) |=> (stat_q[7] != $past(stat_q[7])));
    // R9: bypass is only entered by the bypass command at the command stage
    byp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byp_q) |-> ($past(st_q) == ST_CMD) && ($past(wr_data) == CODE_BYP));
    // R10: any write in query mode goes back to read mode
    query_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_QUERY && wr_en) |=> (st_q == ST_READ));
    // R6 R7: erase requests are single-cycle and exclusive
    erase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prog_en, sect_er, chip_er}) <= 1);
endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the NOR flash command sequencer: sequencer, erase timer, array.
// Assumes AW >= MEM_AW and CHIP_CYC, SECT_CYC >= 1.
module nor_cmd_seq #(
    parameter int            AW       = 12,
    parameter int            MEM_AW   = 8,
    parameter int            SECT_AW  = 6,
    parameter logic [AW-1:0] UNLK0    = 12'h555,
    parameter logic [AW-1:0] UNLK1    = 12'h2AA,
    parameter logic [AW-1:0] QRY_ADDR = 12'h055,
    parameter int            CHIP_CYC = 40,
    parameter int            SECT_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [1:0]        mode_o,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              bypass_o
);
    logic prog_en, sect_er, chip_er, tmr_start, tmr_chip, tmr_done;

    nfc_seq #(.AW(AW), .UNLK0(UNLK0), .UNLK1(UNLK1), .QRY_ADDR(QRY_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_done(tmr_done), .prog_en(prog_en),
        .sect_er(sect_er), .chip_er(chip_er), .tmr_start(tmr_start),
        .tmr_chip(tmr_chip), .mode(mode_o), .status(status_o),
        .busy(busy_o), .bypass(bypass_o)
    );

    nfc_timer #(.CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .sel_chip(tmr_chip),
        .done(tmr_done)
    );

    nfc_array #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sect_er(sect_er),
        .chip_er(chip_er), .idx(wr_addr[MEM_AW-1:0]), .wdata(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/nor_cmd_seq_tb.sv
// Directed bench for nor_cmd_seq: one task per scenario.
module nor_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12, MEM_AW = 8;
    localparam logic [AW-1:0] U0 = 12'h555, U1 = 12'h2AA, QA = 12'h055;
    localparam int CHIP_N = 40, SECT_N = 5;

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [MEM_AW-1:0] rd_addr = '0;
    logic [7:0] rd_data, status_o;
    logic [1:0] mode_o;
    logic busy_o, bypass_o;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .mode_o(mode_o),
        .status_o(status_o), .busy_o(busy_o), .bypass_o(bypass_o));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [MEM_AW-1:0] a, output logic [7:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic unlock();
        wr(U0, 8'hAA); wr(U1, 8'h55);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 mode", mode_o, 0); check("R1 busy", busy_o, 0);
        check("R1 bypass", bypass_o, 0); check("R1 status", status_o, 0);
        peek(8'h00, v); check("R1 byte0", v, 8'hFF);
        peek(8'hFF, v); check("R1 byteFF", v, 8'hFF);
    endtask

    task automatic t_unlock_bad();
        wr(U0, 8'hAA); wr(U1, 8'h54); wr(U0, 8'h90);
        check("R2 bad value", mode_o, 0);
        wr(U0, 8'hAA); wr(U1 + 1, 8'h55); wr(U0, 8'h90);
        check("R2 bad address", mode_o, 0);
        unlock(); wr(U1, 8'h90);
        check("R3 command off UNLK0", mode_o, 0);
        unlock(); wr(U0, 8'h90);
        check("R3 autoselect", mode_o, 1);
        wr(12'h000, 8'hF0);
        check("R5 escape from autoselect", mode_o, 0);
    endtask

    task automatic t_program();
        logic [7:0] v;
        unlock(); wr(U0, 8'hA0);
        check("R4 status mode", mode_o, 3);
        wr(12'h0A3, 8'h5C);
        peek(8'hA3, v); check("R4 program", v, 8'h5C);
        check("R4 status bit7 clear", status_o, 8'hFF);
        check("R4 back to read", mode_o, 0);
        unlock(); wr(U0, 8'hA0); wr(12'h0A3, 8'hF3);
        peek(8'hA3, v); check("R4 AND only", v, 8'h50);
        unlock(); wr(U0, 8'hA0); wr(12'h010, 8'h8F);
        peek(8'h10, v); check("R4 program2", v, 8'h8F);
        check("R4 status bit7 set", status_o, 8'h7F);
    endtask

    task automatic t_escape();
        logic [7:0] v;
        unlock(); wr(U0, 8'hA0); wr(12'h020, 8'hF0);
        peek(8'h20, v); check("R5 F0 as data", v, 8'hF0);
        check("R5 status", status_o, 8'h7F);
        unlock(); wr(U0, 8'h20);
        check("R9 bypass set", bypass_o, 1);
        wr(12'h123, 8'hF0);
        check("R5 F0 clears bypass", bypass_o, 0);
        check("R5 F0 mode", mode_o, 0);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] v;
        unlock(); wr(U0, 8'h77);
        check("R11 mode", mode_o, 0);
        wr(12'h040, 8'h00);
        peek(8'h40, v); check("R11 no program", v, 8'hFF);
    endtask

    task automatic t_query();
        wr(QA, 8'h98);
        check("R10 query direct", mode_o, 2);
        wr(12'h000, 8'h00);
        check("R10 leave query", mode_o, 0);
        unlock(); wr(U0, 8'h90); wr(QA, 8'h98);
        check("R10 query from autoselect", mode_o, 2);
        wr(12'h001, 8'h12);
        check("R10 leave query2", mode_o, 0);
    endtask

    task automatic t_sector();
        logic [7:0] v; int n;
        unlock(); wr(U0, 8'h80); unlock(); wr(12'h0B7, 8'h30);
        check("R7 busy mode", mode_o, 3);
        check("R7 status cleared", status_o, 8'h00);
        peek(8'hA3, v); check("R7 sector erased", v, 8'hFF);
        peek(8'h10, v); check("R7 other sector kept", v, 8'h8F);
        wait_busy(n);
        check("R7 busy length", n, SECT_N);
        check("R8 status flip", status_o, 8'h80);
        check("R8 back to read", mode_o, 0);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        unlock(); wr(U0, 8'hA0); wr(12'h060, 8'h00);
        unlock(); wr(U0, 8'h80); unlock(); wr(12'h07F, 8'h30);
        // now at busy negedge 1
        wr(12'h123, 8'hF0);            // driven at busy negedge 2
        check("R8 F0 ignored", busy_o, 1);
        wr(12'h061, 8'h00);            // negedge 4 (no program pending)
        peek(8'h60, v); check("R8 erased", v, 8'hFF);
        check("R8 still busy", busy_o, 1);
        // at negedge 5 = last busy cycle
        wr_en = 1; wr_addr = U0; wr_data = 8'hAA;
        @(negedge clk); wr_en = 0;
        check("R8 busy ends", busy_o, 0);
        check("R8 status after", status_o, 8'h80);
        wr(U1, 8'h55); wr(U0, 8'h90);
        check("R8 write on final cycle ignored", mode_o, 0);
    endtask

    task automatic t_chip();
        logic [7:0] v; int n;
        unlock(); wr(U0, 8'h80); unlock(); wr(U1, 8'h10);
        check("R6 wrong address", busy_o, 0);
        check("R6 wrong address mode", mode_o, 0);
        peek(8'h10, v); check("R6 no erase", v, 8'h8F);
        unlock(); wr(U0, 8'h80); unlock(); wr(U0, 8'h10);
        peek(8'h10, v); check("R6 chip erase a", v, 8'hFF);
        peek(8'h20, v); check("R6 chip erase b", v, 8'hFF);
        wait_busy(n);
        check("R6 busy length", n, CHIP_N);
    endtask

    task automatic t_bypass();
        logic [7:0] v; int n;
        unlock(); wr(U0, 8'h20);
        wr(12'h300, 8'hA0);
        check("R9 program cmd any addr", mode_o, 3);
        wr(12'h005, 8'h3C);
        peek(8'h05, v); check("R9 bypass program", v, 8'h3C);
        check("R9 stays bypass", bypass_o, 1);
        wr(12'h777, 8'hA0); wr(12'h006, 8'h11);
        peek(8'h06, v); check("R9 second program", v, 8'h11);
        wr(12'h001, 8'h80); wr(U0, 8'hAA); wr(U1, 8'h55); wr(12'h005, 8'h30);
        wait_busy(n);
        check("R8 bypass kept after erase", bypass_o, 1);
        peek(8'h05, v); check("R7 bypass sector erase", v, 8'hFF);
        wr(12'h002, 8'hA0);
        check("R8 returns to command stage", mode_o, 3);
        wr(12'h009, 8'h0F);
        peek(8'h09, v); check("R9 program after erase", v, 8'h0F);
        wr(12'h003, 8'h90);
        check("R9 autoselect in bypass", mode_o, 1);
        wr(12'h004, 8'h00);
        check("R9 bypass left", bypass_o, 0);
        check("R9 read mode", mode_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_unlock_bad();
        t_program();
        t_escape();
        t_bad_cmd();
        t_query();
        t_sector();
        t_collision();
        t_chip();
        t_bypass();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule